// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Controller

This block owns the transmit side of one device-mode IN endpoint whose packet storage is split into two ping-pong halves. Firmware loads a packet byte by byte through a CPU register port into the half it currently owns, then commits it by writing the packet-ready bit. The block queues up to two committed packets. It hands the oldest one to a simple serial-engine port when the host sends an IN token, and it frees that half when the host acknowledges.

Firmware sees a packet-ready bit, which stays set only while both halves are held, and a FIFO-not-empty bit. A sticky endpoint interrupt is raised whenever a half is handed back to the CPU, either because a packet was committed while the other half was free, or because a flush or an acknowledge released a half while packet-ready was set. A flush command drops the oldest queued packet. An IN token that finds nothing queued produces a NAK indication.

CPU register map (`cpu_addr`): 0 = control/status, 1 = FIFO byte write (data in bits 7:0), 2 = max-packet size, 3 = interrupt status (read clears).

Top module: `dbuf_in_ep`

## Requirements
- R1: Each half holds 8 << SIZE_CODE bytes, which is 1024 with the default code 7. When the max-packet register exceeds that value, a packet is clipped to the half size.
- R2: The max-packet register at address 2 resets to 64 and reads back what was written. FIFO bytes written beyond that many in one packet are dropped.
- R3: Control/status bit 0 is packet-ready and bit 1 is FIFO-not-empty, and both read 0 after reset. Writing 1 to bit 0 while no packet is queued commits the load. On the next cycle, packet-ready reads 0, FIFO-not-empty reads 1 and the interrupt is set.
- R4: A commit while exactly one packet is queued sets packet-ready and raises no interrupt. While two packets are queued, FIFO byte writes and further commits are ignored.
- R5: Writing 0 to bits 0 and 1 of the control/status register leaves packet-ready and FIFO-not-empty unchanged.
- R6: Each IN token sends the oldest queued packet. `tx_valid` is high from the cycle after the token until every byte of the packet has been taken with `tx_rd`, and the bytes come out in the order they were written.
- R7: Writing 1 to control/status bit 3 discards only the oldest queued packet, clears packet-ready and sets the interrupt. It has no effect when nothing is queued or while a packet is being sent.
- R8: An ACK during a send releases that packet's half. If packet-ready was set, it clears and the interrupt is set. FIFO-not-empty clears once no packet is queued.
- R9: An IN token with no packet queued pulses `in_nak` for one cycle, and `tx_valid` stays low.
- R10: The interrupt flag is sticky. A read of address 3 returns it in bit 0 and clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (used for read-to-clear) |
| cpu_addr | input | 2 | CPU register address |
| cpu_wdata | input | 11 | CPU write data |
| cpu_rdata | output | 11 | CPU read data (combinational from address) |
| ep_irq | output | 1 | Sticky endpoint interrupt |
| in_tok | input | 1 | Host IN token pulse |
| in_ack | input | 1 | Host ACK pulse |
| tx_rd | input | 1 | Serial engine takes one byte |
| tx_valid | output | 1 | A byte of the current packet is available |
| tx_data | output | 8 | Current packet byte |
| in_nak | output | 1 | One-cycle NAK indication |

## Verification
Every register write, token, byte take and ACK takes effect at the rising edge where it is sampled. Its results appear in the cycle after that edge: status bits, the interrupt, `tx_valid` after a token, and the next `tx_data` after `tx_rd`. `in_nak` is also due in that cycle and lasts exactly one cycle. The bench steps a queue-based model at the same rising edge that the design samples, and compares the interrupt, `tx_valid`, `tx_data` and `in_nak` on every falling edge. Register reads are sampled within the cycle of the read strobe, before the edge that would clear the interrupt.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int CPU_DW = 11;

    typedef enum logic [1:0] {
        A_CSR  = 2'd0,
        A_FIFO = 2'd1,
        A_MAXP = 2'd2,
        A_INT  = 2'd3
    } reg_addr_e;

    localparam int B_PRDY  = 0;
    localparam int B_FNE   = 1;
    localparam int B_FLUSH = 3;

    typedef struct packed {
        logic commit;
        logic flush;
        logic fifo_wr;
        logic maxp_wr;
        logic int_rd;
    } cpu_cmd_t;

    function automatic int half_bytes(input int code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/dbuf_cpu_if.sv
module dbuf_cpu_if
    import dbuf_pkg::*;
(
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    input  logic              prdy,
    input  logic              fne,
    input  logic              irq,
    input  logic [CPU_DW-1:0] maxp,
    output cpu_cmd_t          cmd,
    output logic [CPU_DW-1:0] cpu_rdata
);
    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(cpu_addr);

    always_comb begin
        cmd = '0;
        if (cpu_wr) begin
            unique case (addr_e)
                A_CSR: begin
                    cmd.flush  = cpu_wdata[B_FLUSH];
                    cmd.commit = cpu_wdata[B_PRDY] & ~cpu_wdata[B_FLUSH];
                end
                A_FIFO:  cmd.fifo_wr = 1'b1;
                A_MAXP:  cmd.maxp_wr = 1'b1;
                default: ;
            endcase
        end
        cmd.int_rd = cpu_rd && (addr_e == A_INT);
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (addr_e)
            A_CSR: begin
                cpu_rdata[B_PRDY] = prdy;
                cpu_rdata[B_FNE]  = fne;
            end
            A_MAXP:  cpu_rdata = maxp;
            A_INT:   cpu_rdata[0] = irq;
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbuf_mem.sv
module dbuf_mem #(
    parameter int HALF = 1024,
    localparam int AW  = $clog2(HALF)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wsel,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rsel,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] rd_half [2];

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [7:0] mem [HALF];
        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(g))) mem[waddr] <= wdata;
        end
        assign rd_half[g] = mem[raddr];
    end

    assign rdata = rd_half[rsel];
endmodule

// File: rtl/dbuf_in_ep.sv
module dbuf_in_ep
    import dbuf_pkg::*;
#(
    parameter int SIZE_CODE = 7,
    parameter int MAXP_RST  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              ep_irq,
    input  logic              in_tok,
    input  logic              in_ack,
    input  logic              tx_rd,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              in_nak
);
    localparam int HALF = half_bytes(SIZE_CODE);
    localparam int AW   = $clog2(HALF);
    localparam int LW   = AW + 1;

    typedef struct packed {
        logic [1:0]         cnt;
        logic               wr_idx;
        logic               rd_idx;
        logic [LW-1:0]      wr_len;
        logic [1:0][LW-1:0] len;
        logic               busy;
        logic [LW-1:0]      rd_ptr;
        logic               prdy;
        logic               irq;
        logic               nak;
        logic [CPU_DW-1:0]  maxp;
    } st_t;

    st_t      st_d, st_q;
    cpu_cmd_t cmd;
    logic     mem_we;
    logic [LW-1:0] lim;

    // signals brought out for the bound checker
    logic [1:0] cnt_w;
    logic       busy_w;
    logic       prdy_w;
    assign cnt_w  = st_q.cnt;
    assign busy_w = st_q.busy;
    assign prdy_w = st_q.prdy;

    dbuf_cpu_if u_cpu (
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .prdy      (st_q.prdy),
        .fne       (st_q.cnt != 2'd0),
        .irq       (st_q.irq),
        .maxp      (st_q.maxp),
        .cmd       (cmd),
        .cpu_rdata (cpu_rdata)
    );

    dbuf_mem #(.HALF(HALF)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wsel  (st_q.wr_idx),
        .waddr (st_q.wr_len[AW-1:0]),
        .wdata (cpu_wdata[7:0]),
        .rsel  (st_q.rd_idx),
        .raddr (st_q.rd_ptr[AW-1:0]),
        .rdata (tx_data)
    );

    assign lim      = (st_q.maxp > CPU_DW'(HALF)) ? LW'(HALF) : LW'(st_q.maxp);
    assign tx_valid = st_q.busy && (st_q.rd_ptr < st_q.len[st_q.rd_idx]);
    assign ep_irq   = st_q.irq;
    assign in_nak   = st_q.nak;

    always_comb begin
        st_d     = st_q;
        st_d.nak = 1'b0;
        mem_we   = 1'b0;

        // read-to-clear comes first so any set below wins
        if (cmd.int_rd) st_d.irq = 1'b0;

        // host acknowledge frees the oldest half
        if (in_ack && st_q.busy) begin
            st_d.busy   = 1'b0;
            st_d.rd_idx = ~st_q.rd_idx;
            st_d.cnt    = st_q.cnt - 2'd1;
            if (st_q.prdy) begin
                st_d.prdy = 1'b0;
                st_d.irq  = 1'b1;
            end
        end

        if (tx_rd && tx_valid) st_d.rd_ptr = st_q.rd_ptr + LW'(1);

        if (in_tok && !st_q.busy) begin
            if (st_d.cnt != 2'd0) begin
                st_d.busy   = 1'b1;
                st_d.rd_ptr = '0;
            end else begin
                st_d.nak = 1'b1;
            end
        end

        if (cmd.maxp_wr) st_d.maxp = cpu_wdata;

        if (cmd.fifo_wr && (st_d.cnt != 2'd2) && (st_q.wr_len < lim)) begin
            mem_we      = 1'b1;
            st_d.wr_len = st_q.wr_len + LW'(1);
        end

        if (cmd.commit && (st_d.cnt != 2'd2)) begin
            st_d.len[st_q.wr_idx] = st_q.wr_len;
            st_d.wr_idx = ~st_q.wr_idx;
            st_d.wr_len = '0;
            st_d.cnt    = st_d.cnt + 2'd1;
            if (st_d.cnt == 2'd2) begin
                st_d.prdy = 1'b1;
            end else begin
                st_d.prdy = 1'b0;
                st_d.irq  = 1'b1;
            end
        end

        if (cmd.flush && (st_d.cnt != 2'd0) && !st_q.busy && !st_d.busy) begin
            st_d.rd_idx = ~st_d.rd_idx;
            st_d.cnt    = st_d.cnt - 2'd1;
            st_d.prdy   = 1'b0;
            st_d.irq    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.maxp <= CPU_DW'(MAXP_RST);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dbuf_in_ep_chk.sv
module dbuf_in_ep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [1:0] cpu_addr,
    input logic       ep_irq,
    input logic       in_ack,
    input logic       in_nak,
    input logic       tx_valid,
    input logic [1:0] cnt,
    input logic       busy,
    input logic       prdy
);
    // R4
    prdy_both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prdy |-> cnt == 2'd2);

    // R6
    valid_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> cnt != 2'd0);

    // R8
    ack_frees_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && busy && !cpu_wr) |=> cnt == $past(cnt) - 2'd1);

    // R9
    nak_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_nak |-> ($past(cnt) == 2'd0 && !tx_valid));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_irq && !(cpu_rd && cpu_addr == 2'd3)) |=> ep_irq);
endmodule

bind dbuf_in_ep dbuf_in_ep_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .ep_irq   (ep_irq),
    .in_ack   (in_ack),
    .in_nak   (in_nak),
    .tx_valid (tx_valid),
    .cnt      (cnt_w),
    .busy     (busy_w),
    .prdy     (prdy_w)
);

// File: tb/tb_dbuf_in_ep.sv
module tb_dbuf_in_ep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [10:0] cpu_wdata = '0;
    logic [10:0] cpu_rdata;
    logic        ep_irq, tx_valid, in_nak;
    logic [7:0]  tx_data;
    logic        in_tok = 1'b0, in_ack = 1'b0, tx_rd = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbuf_in_ep dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ep_irq(ep_irq), .in_tok(in_tok), .in_ack(in_ack), .tx_rd(tx_rd),
        .tx_valid(tx_valid), .tx_data(tx_data), .in_nak(in_nak)
    );

    // ---------------- reference model ----------------
    logic [7:0] byte_q [$];
    int         len_q  [$];
    logic [7:0] load_q [$];
    bit  m_irq, m_prdy, m_busy, m_nak, busy_before;
    int  m_off, m_maxp, m_lim;

    always @(posedge clk) begin
        if (!rst_n) begin
            byte_q.delete(); len_q.delete(); load_q.delete();
            m_irq = 0; m_prdy = 0; m_busy = 0; m_nak = 0; m_off = 0; m_maxp = 64;
        end else begin
            busy_before = m_busy;
            m_nak = 0;
            if (cpu_rd && cpu_addr == 2'd3) m_irq = 0;
            if (in_ack && m_busy) begin
                repeat (len_q[0]) void'(byte_q.pop_front());
                void'(len_q.pop_front());
                m_busy = 0;
                if (m_prdy) begin m_prdy = 0; m_irq = 1; end
            end
            if (tx_rd && m_busy && m_off < len_q[0]) m_off++;
            if (in_tok && !busy_before) begin
                if (len_q.size() > 0) begin m_busy = 1; m_off = 0; end
                else m_nak = 1;
            end
            m_lim = (m_maxp > 1024) ? 1024 : m_maxp;
            if (cpu_wr) begin
                case (cpu_addr)
                    2'd1: if (len_q.size() < 2 && load_q.size() < m_lim)
                              load_q.push_back(cpu_wdata[7:0]);
                    2'd2: m_maxp = int'(cpu_wdata);
                    2'd0: begin
                        if (cpu_wdata[3]) begin
                            if (len_q.size() > 0 && !busy_before && !m_busy) begin
                                repeat (len_q[0]) void'(byte_q.pop_front());
                                void'(len_q.pop_front());
                                m_prdy = 0; m_irq = 1;
                            end
                        end else if (cpu_wdata[0] && len_q.size() < 2) begin
                            foreach (load_q[i]) byte_q.push_back(load_q[i]);
                            len_q.push_back(load_q.size());
                            load_q.delete();
                            if (len_q.size() == 2) m_prdy = 1;
                            else begin m_prdy = 0; m_irq = 1; end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit mv;
            mv = m_busy && (len_q.size() > 0) && (m_off < len_q[0]);
            chk(ep_irq == m_irq, "R10 irq", int'(ep_irq), int'(m_irq));
            chk(tx_valid == mv, "R6 tx_valid", int'(tx_valid), int'(mv));
            if (mv && tx_valid)
                chk(tx_data == byte_q[m_off], "R6 tx_data", int'(tx_data), int'(byte_q[m_off]));
            chk(in_nak == m_nak, "R9 in_nak", int'(in_nak), int'(m_nak));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = 11'(d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #5;
        chk(int'(cpu_rdata) == exp, req, int'(cpu_rdata), exp);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic load(input int n, input int seed);
        for (int i = 0; i < n; i++) wr(2'd1, (seed + i * 7) & 255);
    endtask

    task automatic host_pkt(input int exp_len, input bit flush_mid, input string req);
        int n;
        @(negedge clk);
        in_tok = 1'b1;
        @(negedge clk);
        in_tok = 1'b0;
        if (flush_mid) begin
            cpu_wr = 1'b1; cpu_addr = 2'd0; cpu_wdata = 11'd8;
            @(negedge clk);
            cpu_wr = 1'b0;
        end
        n = 0;
        while (tx_valid && n < 5000) begin
            tx_rd = 1'b1; n++;
            @(negedge clk);
            tx_rd = 1'b0;
        end
        chk(n == exp_len, req, n, exp_len);
        in_ack = 1'b1;
        @(negedge clk);
        in_ack = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state, R2 reset max-packet, R10 no interrupt
        rd_chk(2'd0, 0, "R3 reset csr");
        rd_chk(2'd2, 64, "R2 reset maxp");
        rd_chk(2'd3, 0, "R10 reset irq");
        chk(tx_valid == 1'b0, "R6 reset tx_valid", int'(tx_valid), 0);

        wr(2'd2, 800);
        rd_chk(2'd2, 800, "R2 maxp readback");

        // R3 first commit
        load(3, 10);
        wr(2'd0, 1);
        chk(ep_irq == 1'b1, "R3 irq on first commit", int'(ep_irq), 1);
        rd_chk(2'd0, 2, "R3 csr after first commit");
        rd_chk(2'd3, 1, "R10 irq read");
        rd_chk(2'd3, 0, "R10 irq cleared by read");

        // R4 second commit
        load(2, 50);
        wr(2'd0, 1);
        rd_chk(2'd0, 3, "R4 csr both full");
        rd_chk(2'd3, 0, "R4 no irq on second commit");

        // R5 zero write, R4 writes ignored when full
        wr(2'd0, 0);
        rd_chk(2'd0, 3, "R5 zero write no effect");
        load(1, 99);
        wr(2'd0, 1);
        rd_chk(2'd0, 3, "R4 commit ignored when full");
        rd_chk(2'd3, 0, "R4 no irq when full");

        // R7 flush drops oldest only
        wr(2'd0, 8);
        rd_chk(2'd0, 2, "R7 csr after flush of two");
        rd_chk(2'd3, 1, "R7 irq on flush");
        host_pkt(2, 1'b0, "R6 remaining packet length");
        rd_chk(2'd0, 0, "R8 empty after ack");
        rd_chk(2'd3, 0, "R8 no irq without prdy");

        // R9 NAK on empty
        @(negedge clk);
        in_tok = 1'b1;
        @(negedge clk);
        in_tok = 1'b0;
        chk(in_nak == 1'b1, "R9 nak pulse", int'(in_nak), 1);
        chk(tx_valid == 1'b0, "R9 no data", int'(tx_valid), 0);
        @(negedge clk);
        chk(in_nak == 1'b0, "R9 nak one cycle", int'(in_nak), 0);

        // R8 ack with prdy set, R6 order
        load(4, 3); wr(2'd0, 1);
        load(5, 77); wr(2'd0, 1);
        rd_chk(2'd3, 1, "R10 clear before acks");
        host_pkt(4, 1'b0, "R6 first packet length");
        rd_chk(2'd0, 2, "R8 prdy cleared by ack");
        rd_chk(2'd3, 1, "R8 irq on ack");
        host_pkt(5, 1'b0, "R6 second packet length");
        rd_chk(2'd0, 0, "R8 fifo empty");

        // R7 flush on empty does nothing
        wr(2'd0, 8);
        rd_chk(2'd3, 0, "R7 flush empty no irq");

        // R7 flush single packet
        load(3, 5); wr(2'd0, 1);
        rd_chk(2'd3, 1, "R3 irq single");
        wr(2'd0, 8);
        rd_chk(2'd0, 0, "R7 single flush empties");
        rd_chk(2'd3, 1, "R7 single flush irq");

        // R7 two flushes for two packets
        load(2, 1); wr(2'd0, 1);
        load(2, 2); wr(2'd0, 1);
        wr(2'd0, 8);
        rd_chk(2'd0, 2, "R7 one left after flush");
        wr(2'd0, 8);
        rd_chk(2'd0, 0, "R7 empty after second flush");
        rd_chk(2'd3, 1, "R10 clear");

        // R7 flush ignored while sending
        load(6, 9); wr(2'd0, 1);
        host_pkt(6, 1'b1, "R7 flush during send ignored");
        rd_chk(2'd0, 0, "R7 empty after send");
        rd_chk(2'd3, 1, "R10 clear");

        // R2 max-packet clipping
        load(805, 11); wr(2'd0, 1);
        host_pkt(800, 1'b0, "R2 packet clipped to maxp");

        // R1 half-size clipping
        wr(2'd2, 2047);
        rd_chk(2'd2, 2047, "R2 maxp large");
        load(1030, 200); wr(2'd0, 1);
        host_pkt(1024, 1'b0, "R1 packet clipped to half");
        rd_chk(2'd0, 0, "R8 empty at end");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule